// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port that software controls through a small register bus with a two-bit address. Every pin owns three bits. The direction bit picks input or output. The output bit drives the pad when the pin is an output, and it requests a pull-up when the pin is an input. The pin bit returns the pad level after synchronization. The port drives the pad cells through per-pin output-enable and output-data lines. It also produces a per-pin pull-up request, which one chip-wide pull-up disable input can veto.

Pad inputs pass through a two-stage capture pipeline before software can read them. A chip-wide sleep input freezes the first stage, so the value read back stays at its last sample while the chip sleeps. Writing to the pin address does not store anything. Each one in the written data flips the matching output bit. Each zero leaves that bit alone. This lets software toggle pins without a read-modify-write sequence.

Top module: `gpio_port`

## Requirements
- R1: After reset, and again after any later reset, the direction and output registers read 0. `padOe` and `pullEn` are then all zero.
- R2: A write to address 1 with `busWrEn` high loads the direction register on the next rising edge. `padOe` follows the register bit by bit (1 = output) in the same cycle, and a read of address 1 returns the register.
- R3: A write to address 2 loads the output register. `padOut` follows it combinationally. A read of address 2 returns the stored value and not the pad level.
- R4: A write to address 0 flips every output bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R5: A read of address 0 returns the synchronized pad level. A pad change made before rising edge k shows up in the read data after rising edge k+1 and not earlier.
- R6: `pullEn[i]` is 1 exactly when the direction bit is 0, the output bit is 1 and `pullupDisable` is 0.
- R7: While `sleepEn` is 1, the value read at address 0 holds its last sample whatever the pads do. Once sleep ends, the two-edge latency of R5 applies again.
- R8: Address 3 ignores writes and reads as 0. `busRdData` is 0 whenever `busRdEn` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register address: 0 pin, 1 direction, 2 output, 3 reserved |
| busWrEn | input | 1 | Write strobe, taken at the rising edge |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe (combinational read) |
| busRdData | output | 8 | Read data, 0 when not reading |
| pullupDisable | input | 1 | Chip-wide veto of all pull-ups |
| sleepEn | input | 1 | Freezes input sampling |
| padIn | input | 8 | Pad input levels |
| padOe | output | 8 | Per-pin output enable |
| padOut | output | 8 | Per-pin output data |
| pullEn | output | 8 | Per-pin pull-up enable |

## Verification
If the direction or output register is corrupted, the fault shows on `padOe`, `padOut` and `pullEn` in the same cycle, because all three are decoded combinationally from those registers. A wrong toggle or a wrong address decode shows up at the next read of address 2 or 1. A fault in the capture pipeline shows up as the pin value appearing one edge early or late, or as a change getting through during sleep. The bench therefore reads address 0 on every cycle around each pad change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_PIN = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_OUT = 2'd2;

  typedef struct packed {
    logic wrDir;
    logic wrOut;
    logic wrToggle;
    logic rdPin;
    logic rdDir;
    logic rdOut;
  } portStrobes_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic                busRdEn,
  output portStrobes_t        strobes
);

  always_comb begin
    strobes          = '0;
    strobes.wrToggle = busWrEn && (busAddr == ADDR_PIN);
    strobes.wrDir    = busWrEn && (busAddr == ADDR_DIR);
    strobes.wrOut    = busWrEn && (busAddr == ADDR_OUT);
    strobes.rdPin    = busRdEn && (busAddr == ADDR_PIN);
    strobes.rdDir    = busRdEn && (busAddr == ADDR_DIR);
    strobes.rdOut    = busRdEn && (busAddr == ADDR_OUT);
  end

  // R8: at most one register is selected per access
  assert_one_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrDir, strobes.wrOut, strobes.wrToggle}));
  assert_one_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rdPin, strobes.rdDir, strobes.rdOut}));

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hold,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] captureStage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      captureStage <= '0;
      syncOut      <= '0;
    end else begin
      if (!hold) captureStage <= asyncIn;
      syncOut <= captureStage;
    end
  end

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> $stable(captureStage));
  assert_pipe_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> syncOut == $past(captureStage));

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  portStrobes_t         strobes,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic                 pullupDisable,
  input  logic                 sleepEn,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] pullEn,
  output logic [PIN_COUNT-1:0] rdData
);

  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] outReg;
  logic [PIN_COUNT-1:0] pinSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
      outReg <= '0;
    end else begin
      if (strobes.wrDir)         dirReg <= wrData;
      if (strobes.wrOut)         outReg <= wrData;
      else if (strobes.wrToggle) outReg <= outReg ^ wrData;
    end
  end

  gpio_port_sync #(.WIDTH(PIN_COUNT)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .hold    (sleepEn),
    .asyncIn (padIn),
    .syncOut (pinSync)
  );

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    assign padOe[i]  = dirReg[i];
    assign padOut[i] = outReg[i];
    assign pullEn[i] = !dirReg[i] && outReg[i] && !pullupDisable;
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdPin)      rdData = pinSync;
    else if (strobes.rdDir) rdData = dirReg;
    else if (strobes.rdOut) rdData = outReg;
  end

  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrDir |=> $stable(padOe));
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrOut || strobes.wrToggle) |=> $stable(padOut));
  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrToggle |=> padOut == ($past(padOut) ^ $past(wrData)));
  assert_pull_only_input_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pullEn & padOe) == '0);

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [PIN_COUNT-1:0] busWrData,
  input  logic                 busRdEn,
  output logic [PIN_COUNT-1:0] busRdData,
  input  logic                 pullupDisable,
  input  logic                 sleepEn,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] pullEn
);

  portStrobes_t strobes;

  gpio_port_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  gpio_port_datapath #(.PIN_COUNT(PIN_COUNT)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .wrData        (busWrData),
    .pullupDisable (pullupDisable),
    .sleepEn       (sleepEn),
    .padIn         (padIn),
    .padOe         (padOe),
    .padOut        (padOut),
    .pullEn        (pullEn),
    .rdData        (busRdData)
  );

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic       pullupDisable = 1'b0;
  logic       sleepEn = 1'b0;
  logic [7:0] padIn = '0;
  logic [7:0] padOe, padOut, pullEn;

  always #4 clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .pullupDisable(pullupDisable), .sleepEn(sleepEn), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .pullEn(pullEn)
  );

  typedef enum int {SEL_RD, SEL_OE, SEL_OUT, SEL_PULL} sel_t;
  typedef struct {
    string      req;
    sel_t       sel;
    logic [7:0] exp;
  } item_t;

  item_t queueExp[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // monitor: compares after every falling edge, once inputs have settled
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (queueExp.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = queueExp.pop_front();
        case (it.sel)
          SEL_RD:  act = busRdData;
          SEL_OE:  act = padOe;
          SEL_OUT: act = padOut;
          default: act = pullEn;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input string req, input sel_t sel, input logic [7:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    queueExp.push_back(it);
  endtask

  task automatic step(input logic [1:0] a, input logic we, input logic [7:0] d, input logic re);
    @(negedge clk);
    busAddr = a; busWrEn = we; busWrData = d; busRdEn = re;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    step(2'd1, 0, 8'h00, 1);
    expect_val("R1", SEL_RD, 8'h00);
    expect_val("R1", SEL_OE, 8'h00);
    expect_val("R1", SEL_PULL, 8'h00);
    step(2'd2, 0, 8'h00, 1);
    expect_val("R1", SEL_RD, 8'h00);

    // R2 direction
    padIn = 8'hFF;
    step(2'd1, 1, 8'hF0, 0);
    step(2'd1, 0, 8'h00, 1);
    expect_val("R2", SEL_RD, 8'hF0);
    expect_val("R2", SEL_OE, 8'hF0);

    // R3 output register, R6 pull-up
    step(2'd2, 1, 8'h5A, 0);
    step(2'd2, 0, 8'h00, 1);
    expect_val("R3", SEL_RD, 8'h5A);
    expect_val("R3", SEL_OUT, 8'h5A);
    expect_val("R6", SEL_PULL, 8'h0A);
    step(2'd2, 0, 8'h00, 1);
    pullupDisable = 1'b1;
    expect_val("R6", SEL_PULL, 8'h00);
    step(2'd2, 0, 8'h00, 0);
    pullupDisable = 1'b0;
    expect_val("R6", SEL_PULL, 8'h0A);

    // R4 toggle writes
    step(2'd0, 1, 8'h0F, 0);
    step(2'd2, 0, 8'h00, 1);
    expect_val("R4", SEL_RD, 8'h55);
    step(2'd0, 1, 8'h00, 0);
    step(2'd2, 0, 8'h00, 1);
    expect_val("R4", SEL_RD, 8'h55);
    expect_val("R4", SEL_OUT, 8'h55);

    // R5 two-edge latency
    step(2'd0, 0, 8'h00, 1);
    padIn = 8'h3C;
    expect_val("R5", SEL_RD, 8'hFF);
    step(2'd0, 0, 8'h00, 1);
    expect_val("R5", SEL_RD, 8'hFF);
    step(2'd0, 0, 8'h00, 1);
    expect_val("R5", SEL_RD, 8'h3C);

    // R7 sleep freezes sampling
    step(2'd0, 0, 8'h00, 1);
    sleepEn = 1'b1; padIn = 8'hC3;
    expect_val("R7", SEL_RD, 8'h3C);
    for (int k = 0; k < 3; k++) begin
      step(2'd0, 0, 8'h00, 1);
      expect_val("R7", SEL_RD, 8'h3C);
    end
    step(2'd0, 0, 8'h00, 1);
    sleepEn = 1'b0;
    expect_val("R7", SEL_RD, 8'h3C);
    step(2'd0, 0, 8'h00, 1);
    expect_val("R7", SEL_RD, 8'h3C);
    step(2'd0, 0, 8'h00, 1);
    expect_val("R7", SEL_RD, 8'hC3);

    // R8 reserved address and read gating
    step(2'd3, 1, 8'hFF, 0);
    step(2'd1, 0, 8'h00, 1);
    expect_val("R8", SEL_RD, 8'hF0);
    step(2'd2, 0, 8'h00, 1);
    expect_val("R8", SEL_RD, 8'h55);
    step(2'd3, 0, 8'h00, 1);
    expect_val("R8", SEL_RD, 8'h00);
    step(2'd1, 0, 8'h00, 0);
    expect_val("R8", SEL_RD, 8'h00);

    // R1 second reset
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    step(2'd1, 0, 8'h00, 1);
    expect_val("R1", SEL_RD, 8'h00);
    expect_val("R1", SEL_OUT, 8'h00);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule